// File: doc/BRIEF.md
# Data-Space Access Decoder with Core-Owned Registers

This block sits between the load/store unit of a small 8-bit processor and everything that can answer a byte access. Two kinds of request reach it. One is a byte access in the unified data address space. The other is a dedicated I/O port access, which carries only a port number. For each request it chooses a target: the general-purpose register file, one of eight registers that the core owns, or an external byte memory bus. It then performs the write or returns the read byte.

The core-owned registers sit in the top eight I/O ports. They are:

- four extended-address page registers and an extended-jump page register, each holding its byte in bits 23:16 of a 24-bit value;
- the two halves of the stack pointer;
- the status register.

Some of these registers exist only when a configuration parameter enables them. Writes to an absent register vanish without effect. Every other I/O port, and every data address above the I/O window, is forwarded to the memory bus at a fixed base offset. The requester waits until the bus accepts the access. Read data comes back one cycle after the request is accepted.

Top module: `dsd_data_space`

## Requirements
- R1: A data-space request with address below NUM_GPR (32) targets the register file. `rf_addr` carries the address and `rf_we` pulses for a write. A read returns the stored byte, and the memory bus stays idle.
- R2: A data-space address A with NUM_GPR <= A < NUM_GPR+NUM_IO (0x20..0x5F) behaves exactly like an I/O port access to port A-NUM_GPR.
- R3: A data-space address A >= NUM_GPR+NUM_IO (0x60 and up) raises `mem_valid` with `mem_addr` = MEM_BASE + A. `req_ready` stays low until `mem_ready` is high. A read's byte appears on `rsp_data` with `rsp_valid` in the cycle after the handshake.
- R4: An I/O port P below NUM_IO-8 (ports 0x00..0x37) goes to the memory bus at `mem_addr` = MEM_BASE + NUM_GPR + P, with the request's write data and direction.
- R5: Ports 0x38, 0x39, 0x3A and 0x3B are page registers D, X, Y and Z, and port 0x3C is the extended-jump page register. A write stores {data, 16'h0000}. A read returns bits 23:16.
- R6: A write to page register D, X, Y or Z takes effect only if bit 0, 1, 2 or 3 of RAMP_MASK is set; otherwise the register keeps its value. Writes to port 0x3C always take effect.
- R7: A write to port 0x3D replaces stack-pointer bits 7:0 only. A write to port 0x3E replaces bits 15:8 only, and only when SP_WIDE is 1. Reads of 0x3D and 0x3E return bits 7:0 and 15:8.
- R8: Port 0x3F is the status register: a write stores the byte, and a read returns it.
- R9: An access to a core-owned port is accepted in the cycle it is presented. It never raises `mem_valid` or `rf_we`.
- R10: After reset, `rsp_valid` and `mem_valid` are 0, all page registers, the stack pointer and the status register are 0, and an idle request port shows `req_ready` = 1.
- R11: When a read is followed in the very next cycle by a write to the same location, the read's response carries the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_io | input | 1 | 1: req_addr holds an I/O port number; 0: a data-space address |
| req_we | input | 1 | 1: write, 0: read |
| req_addr | input | DAW | Data address or port number |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte valid (one cycle after acceptance) |
| rsp_data | output | 8 | Read byte |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | GW | Register file index |
| rf_wdata | output | 8 | Register file write byte |
| rf_rdata | input | 8 | Register file read byte for rf_addr |
| mem_valid | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory bus write |
| mem_addr | output | MAW | Memory bus byte address |
| mem_wdata | output | 8 | Memory bus write byte |
| mem_rdata | input | 8 | Memory bus read byte, valid with mem_ready |
| mem_ready | input | 1 | Memory bus completes the access |
| page_d | output | 24 | Page register D |
| page_x | output | 24 | Page register X |
| page_y | output | 24 | Page register Y |
| page_z | output | 24 | Page register Z |
| page_ext | output | 24 | Extended-jump page register |
| sp | output | 16 | Stack pointer |
| sreg | output | 8 | Status register |

## Verification
Two functions of this block can coincide in one clock edge:

- returning the response of an accepted read;
- committing a write that was accepted in the next cycle.

The bench provokes this by holding `req_valid` high across two consecutive cycles and switching the request from a read to a write of the same stack-pointer byte or register-file entry. It judges the result in two places. The response seen with the write must carry the pre-write byte. The stack-pointer output, or a later read, must then show the new byte.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned PAGE_W         = 24;
  localparam int unsigned SP_W           = 2 * BYTE_W;
  localparam int unsigned NUM_PAGE       = 5;
  localparam int unsigned NUM_CORE_PORTS = 8;

  // Where an accepted request is served.
  typedef enum logic [1:0] {
    TGT_GPR  = 2'd0,
    TGT_CORE = 2'd1,
    TGT_BUS  = 2'd2
  } dsd_tgt_e;

  // Core-owned port index = port - (NUM_IO - 8); order fixes the port numbers.
  typedef enum logic [2:0] {
    SR_PAGE_D   = 3'd0,
    SR_PAGE_X   = 3'd1,
    SR_PAGE_Y   = 3'd2,
    SR_PAGE_Z   = 3'd3,
    SR_PAGE_EXT = 3'd4,
    SR_SP_LO    = 3'd5,
    SR_SP_HI    = 3'd6,
    SR_STATUS   = 3'd7
  } dsd_sreg_e;

endpackage

// File: rtl/dsd_addr_decode.sv
module dsd_addr_decode
  import dsd_pkg::*;
#(
  parameter int unsigned NUM_GPR  = 32,
  parameter int unsigned NUM_IO   = 64,
  parameter int unsigned DAW      = 16,
  parameter int unsigned MAW      = 24,
  parameter logic [MAW-1:0] MEM_BASE = MAW'('h80_0000),
  localparam int unsigned GW      = $clog2(NUM_GPR),
  localparam int unsigned IOW     = $clog2(NUM_IO)
) (
  input  logic           is_io,
  input  logic [DAW-1:0] addr,
  output dsd_tgt_e       tgt,
  output dsd_sreg_e      core_sel,
  output logic [GW-1:0]  gpr_idx,
  output logic [MAW-1:0] bus_addr
);

  localparam logic [DAW-1:0] GPR_LIM    = DAW'(NUM_GPR);
  localparam logic [DAW-1:0] WINDOW_END = DAW'(NUM_GPR + NUM_IO);
  localparam logic [IOW-1:0] CORE_FIRST = IOW'(NUM_IO - NUM_CORE_PORTS);
  localparam logic [MAW-1:0] IO_BASE    = MEM_BASE + MAW'(NUM_GPR);

  logic           in_io;
  logic [IOW-1:0] port;

  always_comb begin
    in_io    = 1'b0;
    port     = '0;
    tgt      = TGT_GPR;
    core_sel = SR_PAGE_D;
    gpr_idx  = addr[GW-1:0];
    bus_addr = MEM_BASE + MAW'(addr);

    if (is_io) begin
      in_io = 1'b1;
      port  = addr[IOW-1:0];
    end else if (addr < GPR_LIM) begin
      tgt = TGT_GPR;
    end else if (addr < WINDOW_END) begin
      in_io = 1'b1;
      port  = IOW'(addr - GPR_LIM);
    end else begin
      tgt = TGT_BUS;
    end

    if (in_io) begin
      if (port >= CORE_FIRST) begin
        tgt      = TGT_CORE;
        // NUM_IO is a power of two >= 8, so the low three bits give the index.
        core_sel = dsd_sreg_e'(port[2:0]);
      end else begin
        tgt      = TGT_BUS;
        bus_addr = IO_BASE + MAW'(port);
      end
    end
  end

endmodule

// File: rtl/dsd_core_regs.sv
module dsd_core_regs
  import dsd_pkg::*;
#(
  parameter logic [3:0] RAMP_MASK = 4'hF,
  parameter bit         SP_WIDE   = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  dsd_sreg_e                        sel,
  input  logic [BYTE_W-1:0]                wdata,
  output logic [BYTE_W-1:0]                rd_byte,
  output logic [NUM_PAGE-1:0][PAGE_W-1:0]  page_q,
  output logic [SP_W-1:0]                  sp_q,
  output logic [BYTE_W-1:0]                sreg_q
);

  // Extended-jump page register is always writable.
  localparam logic [NUM_PAGE-1:0] PAGE_WR_MASK = {1'b1, RAMP_MASK};

  for (genvar g = 0; g < NUM_PAGE; g++) begin : g_page
    if (PAGE_WR_MASK[g]) begin : g_live
      logic              en;
      logic [PAGE_W-1:0] q_d;
      logic [PAGE_W-1:0] q_r;

      always_comb begin
        en  = wr_en && (sel == dsd_sreg_e'(3'(g)));
        q_d = {wdata, {(PAGE_W - BYTE_W){1'b0}}};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_r <= '0;
        else if (en) q_r <= q_d;
      end

      assign page_q[g] = q_r;
    end else begin : g_fixed
      assign page_q[g] = '0;
    end
  end

  // Stack pointer, low byte.
  logic              sp_lo_en;
  logic [BYTE_W-1:0] sp_lo_r;

  always_comb sp_lo_en = wr_en && (sel == SR_SP_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sp_lo_r <= '0;
    else if (sp_lo_en) sp_lo_r <= wdata;
  end

  assign sp_q[BYTE_W-1:0] = sp_lo_r;

  // Stack pointer, high byte.
  if (SP_WIDE) begin : g_sp_wide
    logic              en;
    logic [BYTE_W-1:0] hi_r;

    always_comb en = wr_en && (sel == SR_SP_HI);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hi_r <= '0;
      else if (en) hi_r <= wdata;
    end

    assign sp_q[SP_W-1:BYTE_W] = hi_r;
  end else begin : g_sp_narrow
    assign sp_q[SP_W-1:BYTE_W] = '0;
  end

  // Status register.
  logic              st_en;
  logic [BYTE_W-1:0] st_r;

  always_comb st_en = wr_en && (sel == SR_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_r <= '0;
    else if (st_en) st_r <= wdata;
  end

  assign sreg_q = st_r;

  // Read selection.
  always_comb begin
    unique case (sel)
      SR_PAGE_D:   rd_byte = page_q[0][PAGE_W-1 -: BYTE_W];
      SR_PAGE_X:   rd_byte = page_q[1][PAGE_W-1 -: BYTE_W];
      SR_PAGE_Y:   rd_byte = page_q[2][PAGE_W-1 -: BYTE_W];
      SR_PAGE_Z:   rd_byte = page_q[3][PAGE_W-1 -: BYTE_W];
      SR_PAGE_EXT: rd_byte = page_q[4][PAGE_W-1 -: BYTE_W];
      SR_SP_LO:    rd_byte = sp_q[BYTE_W-1:0];
      SR_SP_HI:    rd_byte = sp_q[SP_W-1:BYTE_W];
      default:     rd_byte = sreg_q;
    endcase
  end

endmodule

// File: rtl/dsd_rsp.sv
module dsd_rsp
  import dsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  dsd_tgt_e          tgt,
  input  logic [BYTE_W-1:0] gpr_byte,
  input  logic [BYTE_W-1:0] core_byte,
  input  logic [BYTE_W-1:0] bus_byte,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);

  logic              valid_d;
  logic [BYTE_W-1:0] data_d;

  always_comb begin
    valid_d = take;
    unique case (tgt)
      TGT_GPR:  data_d = gpr_byte;
      TGT_CORE: data_d = core_byte;
      default:  data_d = bus_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rsp_data <= '0;
    else if (take) rsp_data <= data_d;
  end

endmodule

// File: rtl/dsd_data_space.sv
module dsd_data_space
  import dsd_pkg::*;
#(
  parameter int unsigned    NUM_GPR   = 32,
  parameter int unsigned    NUM_IO    = 64,
  parameter int unsigned    DAW       = 16,
  parameter int unsigned    MAW       = 24,
  parameter logic [MAW-1:0] MEM_BASE  = MAW'('h80_0000),
  parameter logic [3:0]     RAMP_MASK = 4'hF,
  parameter bit             SP_WIDE   = 1'b1,
  localparam int unsigned   GW        = $clog2(NUM_GPR)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_io,
  input  logic           req_we,
  input  logic [DAW-1:0] req_addr,
  input  logic [7:0]     req_wdata,
  output logic           rsp_valid,
  output logic [7:0]     rsp_data,
  output logic           rf_we,
  output logic [GW-1:0]  rf_addr,
  output logic [7:0]     rf_wdata,
  input  logic [7:0]     rf_rdata,
  output logic           mem_valid,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [7:0]     mem_wdata,
  input  logic [7:0]     mem_rdata,
  input  logic           mem_ready,
  output logic [23:0]    page_d,
  output logic [23:0]    page_x,
  output logic [23:0]    page_y,
  output logic [23:0]    page_z,
  output logic [23:0]    page_ext,
  output logic [15:0]    sp,
  output logic [7:0]     sreg
);

  dsd_tgt_e                        tgt;
  dsd_sreg_e                       core_sel;
  logic [GW-1:0]                   gpr_idx;
  logic [MAW-1:0]                  bus_addr;
  logic                            to_bus;
  logic                            fire;
  logic                            core_we;
  logic                            rd_take;
  logic [BYTE_W-1:0]               core_byte;
  logic [NUM_PAGE-1:0][PAGE_W-1:0] page_q;

  dsd_addr_decode #(
    .NUM_GPR  (NUM_GPR),
    .NUM_IO   (NUM_IO),
    .DAW      (DAW),
    .MAW      (MAW),
    .MEM_BASE (MEM_BASE)
  ) u_decode (
    .is_io    (req_io),
    .addr     (req_addr),
    .tgt      (tgt),
    .core_sel (core_sel),
    .gpr_idx  (gpr_idx),
    .bus_addr (bus_addr)
  );

  // Handshake and strobes: the bus target alone can stall the requester.
  always_comb begin
    to_bus    = (tgt == TGT_BUS);
    mem_valid = req_valid && to_bus;
    req_ready = to_bus ? mem_ready : 1'b1;
    fire      = req_valid && req_ready;
    rf_we     = fire && req_we && (tgt == TGT_GPR);
    core_we   = fire && req_we && (tgt == TGT_CORE);
    rd_take   = fire && !req_we;
  end

  assign mem_we    = req_we;
  assign mem_addr  = bus_addr;
  assign mem_wdata = req_wdata;
  assign rf_addr   = gpr_idx;
  assign rf_wdata  = req_wdata;

  dsd_core_regs #(
    .RAMP_MASK (RAMP_MASK),
    .SP_WIDE   (SP_WIDE)
  ) u_core_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (core_we),
    .sel     (core_sel),
    .wdata   (req_wdata),
    .rd_byte (core_byte),
    .page_q  (page_q),
    .sp_q    (sp),
    .sreg_q  (sreg)
  );

  assign page_d   = page_q[0];
  assign page_x   = page_q[1];
  assign page_y   = page_q[2];
  assign page_z   = page_q[3];
  assign page_ext = page_q[4];

  dsd_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (rd_take),
    .tgt       (tgt),
    .gpr_byte  (rf_rdata),
    .core_byte (core_byte),
    .bus_byte  (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int unsigned MAW       = 24,
  parameter logic [3:0]  RAMP_MASK = 4'hF,
  parameter bit          SP_WIDE   = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_we,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rf_we,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [MAW-1:0] mem_addr,
  input logic [23:0]    page_d,
  input logic [23:0]    page_x,
  input logic [23:0]    page_y,
  input logic [23:0]    page_z,
  input logic [23:0]    page_ext,
  input logic [15:0]    sp
);

  logic [3:0][23:0] pages;
  assign pages = {page_z, page_y, page_x, page_d};

  // R1: register file writes never overlap a bus request
  assert_gpr_excl_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_valid);

  // R3: a pending bus access stalls the requester
  assert_bus_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !req_ready);

  // R3: a stalled bus access holds its address and direction
  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R3: an accepted read answers in the next cycle
  assert_rsp_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_we) |=> rsp_valid);

  // R11: no response without a read accepted one cycle earlier
  assert_rsp_only_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_we) |=> !rsp_valid);

  // R9: anything that is not a bus access is accepted at once
  assert_core_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_valid) |-> req_ready);

  // R5: page register low 16 bits stay zero
  assert_page_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (page_d[15:0] == 16'h0) && (page_x[15:0] == 16'h0) && (page_y[15:0] == 16'h0) &&
    (page_z[15:0] == 16'h0) && (page_ext[15:0] == 16'h0));

  for (genvar g = 0; g < 4; g++) begin : g_drop
    if (!RAMP_MASK[g]) begin : g_absent
      // R6: an absent page register never changes
      assert_page_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pages[g]));
    end
  end

  if (!SP_WIDE) begin : g_sp_narrow
    // R7: narrow stack pointer keeps its high byte
    assert_sp_hi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(sp[15:8]));
  end

endmodule

bind dsd_data_space dsd_checker #(
  .MAW       (MAW),
  .RAMP_MASK (RAMP_MASK),
  .SP_WIDE   (SP_WIDE)
) u_dsd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rf_we     (rf_we),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .page_d    (page_d),
  .page_x    (page_x),
  .page_y    (page_y),
  .page_z    (page_z),
  .page_ext  (page_ext),
  .sp        (sp)
);

// File: tb/dsd_data_space_bench.sv
`timescale 1ns/1ps
module dsd_data_space_bench;

  localparam logic [23:0] BASE = 24'h80_0000;
  localparam logic [3:0]  MASK = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_io = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;

  logic        req_ready, rsp_valid, rf_we, mem_valid, mem_we, mem_ready;
  logic [7:0]  rsp_data, rf_wdata, rf_rdata, mem_wdata, mem_rdata, sreg;
  logic [4:0]  rf_addr;
  logic [23:0] mem_addr, page_d, page_x, page_y, page_z, page_ext;
  logic [15:0] sp;

  logic        n_ready, n_rv, n_rfwe, n_mv, n_mwe;
  logic [7:0]  n_rd, n_rfwd, n_mwd, n_sreg;
  logic [4:0]  n_rfa;
  logic [23:0] n_ma, n_pd, n_px, n_py, n_pz, n_pe;
  logic [15:0] n_sp;

  function automatic logic [7:0] bus_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // Memory bus model with a programmable wait count.
  int wait_cfg = 0;
  int wcnt = 0;
  always @(posedge clk) begin
    if (mem_valid && !mem_ready) wcnt <= wcnt + 1;
    else                         wcnt <= 0;
  end
  assign mem_ready = (wcnt >= wait_cfg);
  assign mem_rdata = bus_byte(mem_addr);

  // Register file storage model.
  logic [7:0] rf_m [0:31];
  always @(posedge clk) if (rf_we) rf_m[rf_addr] <= rf_wdata;
  assign rf_rdata = rf_m[rf_addr];

  dsd_data_space #(.MEM_BASE(BASE), .RAMP_MASK(MASK), .SP_WIDE(1'b1)) u_dsd_data_space (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_io(req_io), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rf_we(rf_we), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .page_d(page_d), .page_x(page_x), .page_y(page_y), .page_z(page_z),
    .page_ext(page_ext), .sp(sp), .sreg(sreg));

  // Minimal configuration: no page registers D..Z, one-byte stack pointer.
  dsd_data_space #(.MEM_BASE(BASE), .RAMP_MASK(4'b0000), .SP_WIDE(1'b0)) u_dsd_data_space_min (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(n_ready),
    .req_io(req_io), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(n_rv), .rsp_data(n_rd), .rf_we(n_rfwe), .rf_addr(n_rfa),
    .rf_wdata(n_rfwd), .rf_rdata(8'h00), .mem_valid(n_mv), .mem_we(n_mwe),
    .mem_addr(n_ma), .mem_wdata(n_mwd), .mem_rdata(8'h00), .mem_ready(1'b1),
    .page_d(n_pd), .page_x(n_px), .page_y(n_py), .page_z(n_pz),
    .page_ext(n_pe), .sp(n_sp), .sreg(n_sreg));

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Results of the last access.
  logic [7:0]  a_rd, a_wd;
  logic        a_rv, a_bus, a_gpr, a_we;
  logic [23:0] a_addr;
  logic [4:0]  a_gaddr;
  int          a_stalls;

  task automatic access(input logic io, input logic we, input logic [15:0] addr,
                        input logic [7:0] wd, input int waits);
    @(negedge clk);
    wait_cfg  = waits;
    req_io    = io;
    req_we    = we;
    req_addr  = addr;
    req_wdata = wd;
    req_valid = 1'b1;
    a_stalls  = 0;
    #1;
    while (!req_ready) begin
      a_stalls++;
      @(negedge clk);
      #1;
    end
    a_bus   = mem_valid;
    a_addr  = mem_addr;
    a_wd    = mem_wdata;
    a_we    = mem_we;
    a_gpr   = rf_we;
    a_gaddr = rf_addr;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    a_rv = rsp_valid;
    a_rd = rsp_data;
  endtask

  // Expected core-owned register state.
  logic [23:0] m_page [0:4];
  logic [15:0] m_sp;
  logic [7:0]  m_sreg;

  task automatic model_write(input int s, input logic [7:0] d);
    if (s < 4) begin
      if (MASK[s]) m_page[s] = {d, 16'h0000};
    end else if (s == 4) m_page[4] = {d, 16'h0000};
    else if (s == 5) m_sp[7:0] = d;
    else if (s == 6) m_sp[15:8] = d;
    else m_sreg = d;
  endtask

  function automatic logic [7:0] model_read(input int s);
    if (s < 5) return m_page[s][23:16];
    if (s == 5) return m_sp[7:0];
    if (s == 6) return m_sp[15:8];
    return m_sreg;
  endfunction

  function automatic string core_tag(input int s);
    if (s < 5) return "R5/R6 core read";
    if (s < 7) return "R7 core read";
    return "R8 core read";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) m_page[i] = '0;
    m_sp = '0;
    m_sreg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R10: reset state
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 mem_valid", mem_valid, 0);
    chk("R10 req_ready", req_ready, 1);
    chk("R10 sp", sp, 0);
    chk("R10 sreg", sreg, 0);
    chk("R10 pages", {page_d, page_ext}, 0);
    chk("R10 pages xyz", {page_x, page_y}, 0);

    // R1: fill and read back the whole register file range
    for (int a = 0; a < 32; a++) begin
      access(1'b0, 1'b1, 16'(a), 8'(a * 11 + 7), 0);
      chk("R1 rf_we", a_gpr, 1);
      chk("R1 rf_addr", a_gaddr, a);
      chk("R1 no bus", a_bus, 0);
    end
    for (int a = 0; a < 32; a++) begin
      access(1'b0, 1'b0, 16'(a), 8'h00, 0);
      chk("R1 read", {a_rv, a_rd}, {1'b1, 8'(a * 11 + 7)});
      chk("R1 no bus on read", a_bus, 0);
    end

    // R4: every non-core I/O port, write and read, varying waits
    for (int p = 0; p < 56; p++) begin
      access(1'b1, 1'b1, 16'(p), 8'(p) ^ 8'h96, p % 3);
      chk("R4 bus write", {a_bus, a_we, a_wd}, {1'b1, 1'b1, 8'(p) ^ 8'h96});
      chk("R4 io addr", a_addr, BASE + 24'd32 + 24'(p));
      chk("R3 stall count", a_stalls, p % 3);
      access(1'b1, 1'b0, 16'(p), 8'h00, 0);
      chk("R4 io read", {a_rv, a_rd}, {1'b1, bus_byte(BASE + 24'd32 + 24'(p))});
    end

    // R2: data-space window onto the same ports
    for (int a = 32; a < 88; a++) begin
      access(1'b0, 1'b0, 16'(a), 8'h00, a % 2);
      chk("R2 window addr", {a_bus, a_addr}, {1'b1, BASE + 24'd32 + 24'(a - 32)});
      chk("R2 window read", {a_rv, a_rd}, {1'b1, bus_byte(BASE + 24'(a))});
    end

    // R3: memory addresses above the I/O window
    for (int a = 96; a < 352; a++) begin
      access(1'b0, (a % 5) == 0, 16'(a), 8'(a), a % 4);
      chk("R3 mem addr", {a_bus, a_addr}, {1'b1, BASE + 24'(a)});
      chk("R3 stall count", a_stalls, a % 4);
      if ((a % 5) != 0) chk("R3 mem read", {a_rv, a_rd}, {1'b1, bus_byte(BASE + 24'(a))});
      else chk("R3 write no rsp", a_rv, 0);
    end
    access(1'b0, 1'b0, 16'hFFFF, 8'h00, 2);
    chk("R3 top addr", {a_addr, a_rd}, {BASE + 24'hFFFF, bus_byte(BASE + 24'hFFFF)});

    // R5..R9: core-owned ports through both access forms
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] d;
        logic [15:0] ad;
        d  = 8'(s * 37 + r * 91 + 5);
        ad = r[0] ? 16'(56 + s) : 16'(88 + s);
        access(r[0], 1'b1, ad, d, 3);
        model_write(s, d);
        chk("R9 no bus/rf/stall", {a_bus, a_gpr, 8'(a_stalls)}, 0);
        chk("R5 page_d", page_d, m_page[0]);
        chk("R6 page_x", page_x, m_page[1]);
        chk("R5 page_y", page_y, m_page[2]);
        chk("R6 page_z", page_z, m_page[3]);
        chk("R6 page_ext", page_ext, m_page[4]);
        chk("R7 sp", sp, m_sp);
        chk("R8 sreg", sreg, m_sreg);
        chk("R6 min page_d", n_pd, 0);
        chk("R6 min page_ext", n_pe, m_page[4]);
        chk("R7 min sp", n_sp, {8'h00, m_sp[7:0]});
      end
      for (int s = 0; s < 8; s++) begin
        access(r[1], 1'b0, r[1] ? 16'(56 + s) : 16'(88 + s), 8'h00, 1);
        chk(core_tag(s), {a_rv, a_rd}, {1'b1, model_read(s)});
      end
    end

    // R11: read then write of the same place in back-to-back cycles
    @(negedge clk);
    req_io = 1'b1; req_we = 1'b0; req_addr = 16'h003D; req_wdata = 8'h00; req_valid = 1'b1;
    @(negedge clk);
    req_we = 1'b1; req_wdata = 8'hE1;
    #1;
    chk("R11 old sp byte", {rsp_valid, rsp_data}, {1'b1, m_sp[7:0]});
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    m_sp[7:0] = 8'hE1;
    chk("R11 sp updated", {rsp_valid, sp}, {1'b0, m_sp});

    @(negedge clk);
    req_io = 1'b0; req_we = 1'b0; req_addr = 16'd5; req_valid = 1'b1;
    @(negedge clk);
    req_we = 1'b1; req_wdata = 8'h4B;
    #1;
    chk("R11 old rf byte", {rsp_valid, rsp_data}, {1'b1, 8'(5 * 11 + 7)});
    @(negedge clk);
    req_valid = 1'b0;
    access(1'b0, 1'b0, 16'd5, 8'h00, 0);
    chk("R11 rf updated", {a_rv, a_rd}, {1'b1, 8'h4B});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule